// File: doc/BRIEF.md
# Mezzanine Site Power Sequencer

This block powers a mezzanine card site up and down from a single-clock system controller. Power-up starts only when the host processor raises its enable line and the card pulls its active-low presence pin low. The rails then come up one at a time. First the +12 V rail turns on. Next the adjustable rail and its pre-driver supply turn on together. The +3.3 V rail turns on last, and only after the adjustable rail reports power-good. After one more settle interval the block asserts a power-good indication toward the card.

The adjustable-rail voltage code comes from three switch inputs, which are active low. When all three switches are off, the code comes from three processor GPIO lines instead. The code is captured when sequencing leaves idle and stays fixed while any rail is on. A pre-driver select output is derived from the captured code, and a status LED follows the adjustable rail's power-good input.

Several events end the powered state. If the processor drops its enable or the card is removed, the block shuts down in reverse order. If the adjustable rail does not report good in time, the block enters a latched fault and stays there until the processor enable is released. All asynchronous inputs pass through two-flop synchronizers before use.

Top module: `fmc_pwr_seq`

## Requirements
- R1: No rail is enabled unless the enable input is 1 and the active-low presence input is 0 at the same time. With the card absent (presence = 1), all enables stay 0.
- R2: On power-up the rails rise in this order: en12v, then enAdj together with enPreDrv, then en3v3. Each rise comes at least SETTLE_CYCLES clock cycles after the one before it.
- R3: cardPgood is 1 only while en3v3 is 1, and it rises at least SETTLE_CYCLES cycles after en3v3.
- R4: en3v3 rises only after the synchronized adjustable power-good input has been seen high.
- R5: vidCode equals the switch inputs vselSwN[2:0], where 0 means a switch is on. Codes 000 to 110 select 3.3, 2.5, 1.8, 1.5, 1.25, 1.2 and 0.8 V. When vselSwN is 111, vidCode equals cpuVsel[2:0]. A new value reaches vidCode within 5 cycles while idle.
- R6: preDrvSel is 1 when vidCode is 000 (the 3.3 V setting) and 0 for every other code.
- R7: adjLed follows the adjPgood input through a two-flop synchronizer.
- R8: vidCode does not change while en12v is 1. After power-down completes, vidCode again tracks the switches.
- R9: If adjPgood is not seen within PG_TIMEOUT cycles of the adjustable rail turning on, all enables drop to 0. They stay at 0 while the enable input remains 1. Sequencing can start again only after the enable input has gone to 0.
- R10: When the enable input drops, cardPgood falls first. Then en3v3, then enAdj with enPreDrv, then en12v fall in that order, each at least SETTLE_CYCLES cycles after the previous one.
- R11: Taking the card away (presence = 1) while powered triggers the same ordered power-down as R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuEnable | input | 1 | Processor request to power the site |
| cardPresentN | input | 1 | Card presence, 0 = card fitted |
| vselSwN | input | 3 | Voltage switches, 0 = on |
| cpuVsel | input | 3 | Processor-driven voltage code |
| adjPgood | input | 1 | Adjustable rail power-good |
| en12v | output | 1 | +12 V rail enable |
| enAdj | output | 1 | Adjustable rail enable |
| enPreDrv | output | 1 | Pre-driver supply enable |
| en3v3 | output | 1 | +3.3 V rail enable |
| cardPgood | output | 1 | Power-good indication to the card |
| vidCode | output | 3 | Adjustable rail voltage code |
| preDrvSel | output | 1 | Pre-driver level select, 1 = 3.3 V setting |
| adjLed | output | 1 | Adjustable rail status LED |

## Verification
The bench records the cycle on which each enable rises and falls, and checks both the order and the spacing. A design that overlapped stages, or reversed the power-down order, would show a gap below SETTLE_CYCLES or an inverted sequence. The bench holds the regulator model's power-good low to force a timeout. A design that kept retrying, or left the +12 V rail on after the fault, would show an enable during the held-off window. The bench also changes the switches while the site is powered and removes the card mid-operation. These steps expose a voltage code that is not frozen, and a power-down that only reacts to the processor enable.

// File: rtl/fmc_seq_pkg.sv
package fmc_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_UP12, ST_UPADJ, ST_UP33, ST_ON,
    ST_DNALL, ST_DNADJ, ST_DN12, ST_FAULT
  } seqState_t;

  typedef struct packed {
    logic rail12;
    logic railAdj;
    logic rail33;
    logic cardGood;
    logic holdCode;
    logic cntClr;
  } seqCmd_t;
endpackage

// File: rtl/fmc_seq_sync.sv
module fmc_seq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '0;
        else if (s == 0) chain[s] <= asyncIn;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/fmc_seq_ctrl.sv
module fmc_seq_ctrl
  import fmc_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cpuEnS,
  input  logic    presNS,
  input  logic    adjPgS,
  input  logic    settleDone,
  input  logic    timeoutHit,
  output seqCmd_t cmd
);
  seqState_t state, nextState;
  logic goReq;

  assign goReq = cpuEnS && !presNS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:  if (goReq) nextState = ST_UP12;
      ST_UP12:  if (!goReq) nextState = ST_DN12;
                else if (settleDone) nextState = ST_UPADJ;
      ST_UPADJ: if (!goReq) nextState = ST_DNADJ;
                else if (settleDone && adjPgS) nextState = ST_UP33;
                else if (timeoutHit) nextState = ST_FAULT;
      ST_UP33:  if (!goReq) nextState = ST_DNALL;
                else if (settleDone) nextState = ST_ON;
      ST_ON:    if (!goReq) nextState = ST_DNALL;
      ST_DNALL: if (settleDone) nextState = ST_DNADJ;
      ST_DNADJ: if (settleDone) nextState = ST_DN12;
      ST_DN12:  if (settleDone) nextState = ST_IDLE;
      ST_FAULT: if (!cpuEnS) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    cmd          = '0;
    cmd.rail12   = state inside {ST_UP12, ST_UPADJ, ST_UP33, ST_ON,
                                 ST_DNALL, ST_DNADJ, ST_DN12};
    cmd.railAdj  = state inside {ST_UPADJ, ST_UP33, ST_ON, ST_DNALL, ST_DNADJ};
    cmd.rail33   = state inside {ST_UP33, ST_ON, ST_DNALL};
    cmd.cardGood = (state == ST_ON);
    cmd.holdCode = (state != ST_IDLE);
    cmd.cntClr   = (nextState != state);
  end
endmodule

// File: rtl/fmc_seq_dp.sv
module fmc_seq_dp
  import fmc_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8,
  parameter int PG_TIMEOUT    = 40,
  parameter int CODE_W        = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic [CODE_W-1:0] swNS,
  input  logic [CODE_W-1:0] cpuSelS,
  output logic              settleDone,
  output logic              timeoutHit,
  output logic              en12v,
  output logic              enAdj,
  output logic              enPreDrv,
  output logic              en3v3,
  output logic              cardPgood,
  output logic [CODE_W-1:0] vidCode,
  output logic              preDrvSel
);
  localparam int CNT_W = $clog2(PG_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX     = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] TMO_LAST    = CNT_W'(PG_TIMEOUT - 1);

  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] liveCode;
  logic [CODE_W-1:0] selCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (cmd.cntClr) cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign settleDone = (cnt >= SETTLE_LAST);
  assign timeoutHit = (cnt >= TMO_LAST);

  assign liveCode = (&swNS) ? cpuSelS : swNS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selCode <= '0;
    else if (!cmd.holdCode) selCode <= liveCode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en12v     <= 1'b0;
      enAdj     <= 1'b0;
      enPreDrv  <= 1'b0;
      en3v3     <= 1'b0;
      cardPgood <= 1'b0;
    end else begin
      en12v     <= cmd.rail12;
      enAdj     <= cmd.railAdj;
      enPreDrv  <= cmd.railAdj;
      en3v3     <= cmd.rail33;
      cardPgood <= cmd.cardGood;
    end
  end

  assign vidCode   = selCode;
  assign preDrvSel = (selCode == '0);
endmodule

// File: rtl/fmc_pwr_seq.sv
module fmc_pwr_seq
  import fmc_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8,
  parameter int PG_TIMEOUT    = 40,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuEnable,
  input  logic       cardPresentN,
  input  logic [2:0] vselSwN,
  input  logic [2:0] cpuVsel,
  input  logic       adjPgood,
  output logic       en12v,
  output logic       enAdj,
  output logic       enPreDrv,
  output logic       en3v3,
  output logic       cardPgood,
  output logic [2:0] vidCode,
  output logic       preDrvSel,
  output logic       adjLed
);
  localparam int SYNC_W = 9;

  logic [SYNC_W-1:0] rawIn, syncIn;
  logic cpuEnS, presNS, adjPgS, settleDone, timeoutHit;
  logic [2:0] swNS, cpuSelS;
  seqCmd_t cmd;

  assign rawIn = {cpuEnable, cardPresentN, vselSwN, cpuVsel, adjPgood};
  assign {cpuEnS, presNS, swNS, cpuSelS, adjPgS} = syncIn;

  fmc_seq_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .asyncIn(rawIn), .syncOut(syncIn)
  );

  fmc_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cpuEnS(cpuEnS), .presNS(presNS),
    .adjPgS(adjPgS), .settleDone(settleDone), .timeoutHit(timeoutHit),
    .cmd(cmd)
  );

  fmc_seq_dp #(.SETTLE_CYCLES(SETTLE_CYCLES), .PG_TIMEOUT(PG_TIMEOUT), .CODE_W(3)) i_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .swNS(swNS), .cpuSelS(cpuSelS),
    .settleDone(settleDone), .timeoutHit(timeoutHit),
    .en12v(en12v), .enAdj(enAdj), .enPreDrv(enPreDrv), .en3v3(en3v3),
    .cardPgood(cardPgood), .vidCode(vidCode), .preDrvSel(preDrvSel)
  );

  assign adjLed = adjPgS;
endmodule

// File: rtl/fmc_seq_chk.sv
module fmc_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       en12v,
  input logic       enAdj,
  input logic       en3v3,
  input logic       cardPgood,
  input logic [2:0] vidCode,
  input logic       adjLed
);
  // R2
  adj_needs_12v_chk: assert property (@(posedge clk) disable iff (!rstN)
    enAdj |-> en12v);

  // R2
  rail33_needs_lower_chk: assert property (@(posedge clk) disable iff (!rstN)
    en3v3 |-> (en12v && enAdj));

  // R3
  card_good_needs_33_chk: assert property (@(posedge clk) disable iff (!rstN)
    cardPgood |-> en3v3);

  // R4
  rail33_after_pgood_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(en3v3) |-> $past(adjLed, 2));

  // R8
  code_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en12v && $past(en12v)) |-> $stable(vidCode));

  // R10
  rail12_last_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(en12v) |-> !enAdj);
endmodule

bind fmc_pwr_seq fmc_seq_chk i_chk (.*);

// File: tb/test_fmc_pwr_seq.sv
module test_fmc_pwr_seq;
  localparam int SETTLE = 8;
  localparam int TMO    = 40;

  logic clk = 1'b0, rstN = 1'b0;
  logic cpuEnable = 1'b0, cardPresentN = 1'b1;
  logic [2:0] vselSwN = 3'b010, cpuVsel = 3'b101;
  logic adjPgood = 1'b0;
  logic autoPg = 1'b1, ledForce = 1'b0;
  logic en12v, enAdj, enPreDrv, en3v3, cardPgood, preDrvSel, adjLed;
  logic [2:0] vidCode;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  always @(negedge clk) adjPgood <= (autoPg & enAdj) | ledForce;

  fmc_pwr_seq #(.SETTLE_CYCLES(SETTLE), .PG_TIMEOUT(TMO)) i_fmc_pwr_seq (
    .clk(clk), .rstN(rstN), .cpuEnable(cpuEnable), .cardPresentN(cardPresentN),
    .vselSwN(vselSwN), .cpuVsel(cpuVsel), .adjPgood(adjPgood),
    .en12v(en12v), .enAdj(enAdj), .enPreDrv(enPreDrv), .en3v3(en3v3),
    .cardPgood(cardPgood), .vidCode(vidCode), .preDrvSel(preDrvSel), .adjLed(adjLed)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measureUp(output int t12, output int tAdj, output int t33, output int tPg);
    t12 = -1; tAdj = -1; t33 = -1; tPg = -1;
    for (int c = 0; c < 1000 && tPg < 0; c++) begin
      @(negedge clk);
      if (en12v && t12 < 0) t12 = c;
      if (enAdj && tAdj < 0) begin
        tAdj = c;
        chk(enPreDrv == 1'b1, "R2 predrv with adj", enPreDrv, 1);
      end
      if (en3v3 && t33 < 0) t33 = c;
      if (cardPgood && tPg < 0) tPg = c;
    end
  endtask

  task automatic measureDown(output int fPg, output int f33, output int fAdj, output int f12);
    fPg = -1; f33 = -1; fAdj = -1; f12 = -1;
    for (int c = 0; c < 1000 && f12 < 0; c++) begin
      @(negedge clk);
      if (!cardPgood && fPg < 0) fPg = c;
      if (!en3v3 && f33 < 0) f33 = c;
      if (!enAdj && fAdj < 0) fAdj = c;
      if (!en12v && f12 < 0) f12 = c;
    end
  endtask

  task automatic testReset();
    chk(!en12v && !enAdj && !enPreDrv && !en3v3 && !cardPgood, "R1 reset enables",
        {en12v, enAdj, en3v3, cardPgood}, 0);
  endtask

  task automatic testCodes();
    for (int s = 0; s < 8; s++) begin
      vselSwN = 3'(s);
      waitCyc(5);
      chk(vidCode == ((s == 7) ? 3'b101 : 3'(s)), "R5 code select", vidCode, (s == 7) ? 5 : s);
      chk(preDrvSel == (vidCode == 3'b000), "R6 predriver select", preDrvSel, (vidCode == 3'b000));
    end
    cpuVsel = 3'b000;
    waitCyc(5);
    chk(vidCode == 3'b000 && preDrvSel, "R5 R6 cpu code 000", vidCode, 0);
    cpuVsel = 3'b101;
  endtask

  task automatic testNoCard();
    int bad = 0;
    cardPresentN = 1'b1;
    cpuEnable = 1'b1;
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      if (en12v || enAdj || en3v3) bad++;
    end
    chk(bad == 0, "R1 no start without card", bad, 0);
    cpuEnable = 1'b0;
    cardPresentN = 1'b0;
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      if (en12v || enAdj || en3v3) bad++;
    end
    chk(bad == 0, "R1 no start without enable", bad, 0);
  endtask

  task automatic testLed();
    ledForce = 1'b1;
    waitCyc(4);
    chk(adjLed == 1'b1, "R7 led on", adjLed, 1);
    ledForce = 1'b0;
    waitCyc(4);
    chk(adjLed == 1'b0, "R7 led off", adjLed, 0);
  endtask

  task automatic checkUpOrder();
    int t12, tAdj, t33, tPg;
    measureUp(t12, tAdj, t33, tPg);
    chk(t12 >= 0 && tAdj - t12 >= SETTLE, "R2 12v to adj gap", tAdj - t12, SETTLE);
    chk(t33 - tAdj >= SETTLE, "R2 adj to 3v3 gap", t33 - tAdj, SETTLE);
    chk(tPg >= 0 && tPg - t33 >= SETTLE, "R3 3v3 to pgood gap", tPg - t33, SETTLE);
  endtask

  task automatic checkDownOrder(input string tag);
    int fPg, f33, fAdj, f12;
    measureDown(fPg, f33, fAdj, f12);
    chk(f33 - fPg >= SETTLE, {tag, " pgood before 3v3"}, f33 - fPg, SETTLE);
    chk(fAdj - f33 >= SETTLE, {tag, " 3v3 before adj"}, fAdj - f33, SETTLE);
    chk(f12 - fAdj >= SETTLE && !enPreDrv, {tag, " adj before 12v"}, f12 - fAdj, SETTLE);
  endtask

  task automatic testPowerCycle();
    vselSwN = 3'b011;
    waitCyc(5);
    cardPresentN = 1'b0;
    cpuEnable = 1'b1;
    checkUpOrder();
    vselSwN = 3'b110;
    waitCyc(10);
    chk(vidCode == 3'b011, "R8 code frozen while on", vidCode, 3);
    cpuEnable = 1'b0;
    checkDownOrder("R10");
    waitCyc(5);
    chk(vidCode == 3'b110, "R8 code tracks after off", vidCode, 6);
  endtask

  task automatic testCardRemoval();
    cardPresentN = 1'b0;
    cpuEnable = 1'b1;
    checkUpOrder();
    cardPresentN = 1'b1;
    checkDownOrder("R11");
    cpuEnable = 1'b0;
    cardPresentN = 1'b0;
    waitCyc(5);
  endtask

  task automatic testFault();
    int bad = 0, t12, tAdj, t33, tPg;
    autoPg = 1'b0;
    cpuEnable = 1'b1;
    for (int c = 0; c < 200 && !enAdj; c++) @(negedge clk);
    for (int c = 0; c < 200 && enAdj; c++) begin
      @(negedge clk);
      if (en3v3) bad++;
    end
    chk(bad == 0, "R4 no 3v3 without pgood", bad, 0);
    chk(!en12v && !enAdj && !en3v3 && !cardPgood, "R9 fault drops all",
        {en12v, enAdj, en3v3}, 0);
    autoPg = 1'b1;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (en12v || enAdj) bad++;
    end
    chk(bad == 0, "R9 fault held while enabled", bad, 0);
    cpuEnable = 1'b0;
    waitCyc(10);
    cpuEnable = 1'b1;
    measureUp(t12, tAdj, t33, tPg);
    chk(tPg >= 0, "R9 restart after release", tPg, 1);
    cpuEnable = 1'b0;
    waitCyc(60);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitCyc(3);
    testReset();
    rstN = 1'b1;
    waitCyc(2);
    testReset();
    testCodes();
    testLed();
    testNoCard();
    testPowerCycle();
    testCardRemoval();
    testFault();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule